// File: doc/BRIEF.md
# Frequency-trimmable nanosecond time counter

This block turns a raw 32-bit tick count, which advances one count every 8 ns, into a 64-bit nanosecond time of day. On every clock it takes the number of ticks since the previous clock, modulo 2^32, and scales them by a multiplier held in fixed point with 28 fractional bits. It adds the whole nanoseconds to the time value and keeps the sub-nanosecond remainder. The nominal multiplier is the tick period shifted left by 28. A hardware divider computes the trim to that multiplier from a signed scaled-ppm request, where one unit is 2^-16 ppm.

A controller can do three things. It can trim the frequency through a valid/ready request. The request is held off while a division is running: `trim_ready` stays low from acceptance until the new multiplier is loaded, and a `trim_valid` seen while `trim_ready` is low is dropped, not queued. It can step the time by a signed nanosecond offset. It can load an absolute time. Step and set are plain one-cycle strobes that are always taken. The current time and the current multiplier are available on plain output ports at all times.

Top module: `ttc_time_counter`

## Requirements
- R1: While `rst_n` is low, `time_ns` is 0, `cur_mult` is 8·2^28 (2147483648) and `trim_ready` is 1. The tick value present at reset is the counting reference, so time stays 0 until `tick_count` moves.
- R2: Each clock adds floor((frac + d·cur_mult) / 2^28) to `time_ns`. Here d is `tick_count` minus its value one clock earlier, and frac is the kept remainder. At the nominal multiplier each tick adds exactly 8 ns, and a held `tick_count` leaves the time unchanged.
- R3: d is taken modulo 2^32, so a wrap of `tick_count` from 0xFFFFFFFC to 0x00000004 adds 8 ticks (64 ns) and causes no jump.
- R4: The 28-bit remainder is carried from clock to clock, not dropped. With multiplier 2147483648+2147483 and one tick per clock after a set, the time reads 1000 after 125 ticks and 1009 after 126.
- R5: A trim request s loads `cur_mult` = 2147483648 + floor(|s|·512/15625) for s ≥ 0, and 2147483648 − floor(|s|·512/15625) for s < 0.
- R6: Before the division, s is clamped to the range ±65536000, which is ±1,000,000 ppb. Any larger magnitude gives the trim 2147483.
- R7: A multiplier change applies only to ticks that arrive after it is loaded. Time already accumulated, including the remainder, is never rescaled.
- R8: `trim_ready` drops on the clock after a request is accepted and stays low until the new multiplier is loaded. A `trim_valid` seen while `trim_ready` is low has no effect on `cur_mult`.
- R9: A `step_valid` strobe adds the two's-complement `step_delta` to the time on the next clock, together with the normal tick advance. It leaves `cur_mult` unchanged.
- R10: A `set_valid` strobe loads `set_ns` on the next clock, clears the remainder and discards the ticks of that clock. Counting restarts from the current `tick_count`. If set and step arrive in the same clock, set wins.
- R11: A trim completes, with `trim_ready` high again and the new `cur_mult` visible, within 37 clocks of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_count | input | 32 | Free-running raw tick count, 8 ns per count |
| trim_valid | input | 1 | Frequency trim request |
| trim_ready | output | 1 | Trim request can be accepted |
| trim_sppm | input | 32 | Signed trim in units of 2^-16 ppm |
| step_valid | input | 1 | Step strobe |
| step_delta | input | 64 | Signed step offset in ns |
| set_valid | input | 1 | Set strobe |
| set_ns | input | 64 | Absolute time to load, ns |
| time_ns | output | 64 | Current time of day, ns |
| cur_mult | output | 32 | Current multiplier, 28 fractional bits |

## Verification
The bound checker watches several properties on every clock:
- the multiplier changes only at the end of a busy period and stays inside its clamped band;
- an accepted trim always lowers `trim_ready`;
- set loads the requested time exactly;
- a step with a held tick count moves the time by exactly the offset;
- a held tick count with no strobe freezes the time;
- without step or set, time never moves backwards.

Only the bench scenarios can show the arithmetic against independent numbers: the quotient values and clamping, the carry of the remainder across 126 single-tick clocks, the 2^32 wrap, and that ticks counted before a trim keep their old scaling.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam int TTC_TICK_W   = 32;
  localparam int TTC_FRAC_W   = 28;
  localparam int TTC_TIME_W   = 64;
  localparam int TTC_MULT_W   = 32;
  localparam int TTC_PPM_W    = 32;
  localparam int TTC_TICK_NS  = 8;
  localparam int TTC_NUM_SH   = 9;
  localparam int TTC_DEN      = 15625;
  localparam int TTC_MAX_SPPM = 65536000;
endpackage

// File: rtl/ttc_div.sv
module ttc_div #(
  parameter int DVD_W = 35,
  parameter int DEN   = 15625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int DEN_W = $clog2(DEN + 1);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] dvd_q;
  logic [DEN_W-1:0] rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   rem_sh, rem_nx;
  logic             ge;

  // one restoring step: shift in the next dividend bit, subtract if it fits
  always_comb begin
    rem_sh = {rem_q, dvd_q[DVD_W-1]};
    ge     = rem_sh >= (DEN_W+1)'(DEN);
    rem_nx = ge ? rem_sh - (DEN_W+1)'(DEN) : rem_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        dvd_q <= {dvd_q[DVD_W-2:0], ge};
        rem_q <= rem_nx[DEN_W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        dvd_q  <= dividend;
        rem_q  <= '0;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = dvd_q;
endmodule

// File: rtl/ttc_trim.sv
module ttc_trim #(
  parameter int MULT_W   = 32,
  parameter int PPM_W    = 32,
  parameter int FRAC_W   = 28,
  parameter int TICK_NS  = 8,
  parameter int MAX_SPPM = 65536000,
  parameter int NUM_SH   = 9,
  parameter int DEN      = 15625
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trim_valid,
  input  logic signed [PPM_W-1:0] trim_sppm,
  output logic                    trim_ready,
  output logic [MULT_W-1:0]       mult
);
  localparam int MAG_W = $clog2(MAX_SPPM + 1);
  localparam int DVD_W = MAG_W + NUM_SH;
  localparam logic [MULT_W-1:0] NOM_M = MULT_W'(longint'(TICK_NS) << FRAC_W);

  logic signed [PPM_W-1:0] lim_p, lim_n, clip, mag_full;
  logic [MAG_W-1:0]        mag;
  logic [DVD_W-1:0]        dividend, quo;
  logic                    accept, div_busy, div_done, neg_q;
  logic [MULT_W-1:0]       mult_q, q_m;

  always_comb begin
    lim_p = PPM_W'(MAX_SPPM);
    lim_n = -lim_p;
    if (trim_sppm > lim_p)      clip = lim_p;
    else if (trim_sppm < lim_n) clip = lim_n;
    else                        clip = trim_sppm;
    mag_full = clip[PPM_W-1] ? -clip : clip;
    mag      = MAG_W'(mag_full);
    dividend = {mag, {NUM_SH{1'b0}}};
  end

  assign trim_ready = !(div_busy || div_done);
  assign accept     = trim_valid && trim_ready;

  ttc_div #(.DVD_W(DVD_W), .DEN(DEN)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept), .dividend(dividend),
    .busy(div_busy), .done(div_done), .quotient(quo)
  );

  assign q_m = MULT_W'(quo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      mult_q <= NOM_M;
    end else begin
      if (accept) neg_q <= trim_sppm[PPM_W-1];
      if (div_done) mult_q <= neg_q ? NOM_M - q_m : NOM_M + q_m;
    end
  end

  assign mult = mult_q;
endmodule

// File: rtl/ttc_accum.sv
module ttc_accum #(
  parameter int TICK_W = 32,
  parameter int FRAC_W = 28,
  parameter int TIME_W = 64,
  parameter int MULT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_count,
  input  logic [MULT_W-1:0] mult,
  input  logic              step_valid,
  input  logic [TIME_W-1:0] step_delta,
  input  logic              set_valid,
  input  logic [TIME_W-1:0] set_ns,
  output logic [TIME_W-1:0] time_ns
);
  localparam int PROD_W = TICK_W + MULT_W;

  logic [TICK_W-1:0]   ref_q, delta;
  logic [FRAC_W-1:0]   frac_q;
  logic [TIME_W-1:0]   ns_q, add_step;
  logic [PROD_W-1:0]   prod;
  logic [PROD_W:0]     sum;

  always_comb begin
    delta    = tick_count - ref_q;              // modulo 2^TICK_W
    prod     = PROD_W'(delta) * PROD_W'(mult);
    sum      = {1'b0, prod} + (PROD_W+1)'(frac_q);
    add_step = step_valid ? step_delta : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= tick_count;
      frac_q <= '0;
      ns_q   <= '0;
    end else begin
      ref_q <= tick_count;
      if (set_valid) begin
        ns_q   <= set_ns;
        frac_q <= '0;
      end else begin
        ns_q   <= ns_q + TIME_W'(sum >> FRAC_W) + add_step;
        frac_q <= sum[FRAC_W-1:0];
      end
    end
  end

  assign time_ns = ns_q;
endmodule

// File: rtl/ttc_time_counter.sv
module ttc_time_counter
  import ttc_pkg::*;
#(
  parameter int TICK_W   = TTC_TICK_W,
  parameter int FRAC_W   = TTC_FRAC_W,
  parameter int TIME_W   = TTC_TIME_W,
  parameter int MULT_W   = TTC_MULT_W,
  parameter int PPM_W    = TTC_PPM_W,
  parameter int TICK_NS  = TTC_TICK_NS,
  parameter int NUM_SH   = TTC_NUM_SH,
  parameter int DEN      = TTC_DEN,
  parameter int MAX_SPPM = TTC_MAX_SPPM
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TICK_W-1:0]       tick_count,
  input  logic                    trim_valid,
  output logic                    trim_ready,
  input  logic signed [PPM_W-1:0] trim_sppm,
  input  logic                    step_valid,
  input  logic [TIME_W-1:0]       step_delta,
  input  logic                    set_valid,
  input  logic [TIME_W-1:0]       set_ns,
  output logic [TIME_W-1:0]       time_ns,
  output logic [MULT_W-1:0]       cur_mult
);
  logic [MULT_W-1:0] mult;

  ttc_trim #(
    .MULT_W(MULT_W), .PPM_W(PPM_W), .FRAC_W(FRAC_W), .TICK_NS(TICK_NS),
    .MAX_SPPM(MAX_SPPM), .NUM_SH(NUM_SH), .DEN(DEN)
  ) u_trim (
    .clk(clk), .rst_n(rst_n), .trim_valid(trim_valid), .trim_sppm(trim_sppm),
    .trim_ready(trim_ready), .mult(mult)
  );

  ttc_accum #(
    .TICK_W(TICK_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W), .MULT_W(MULT_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .tick_count(tick_count), .mult(mult),
    .step_valid(step_valid), .step_delta(step_delta),
    .set_valid(set_valid), .set_ns(set_ns), .time_ns(time_ns)
  );

  assign cur_mult = mult;
endmodule

// File: rtl/ttc_time_counter_chk.sv
module ttc_time_counter_chk #(
  parameter int TICK_W   = 32,
  parameter int FRAC_W   = 28,
  parameter int TIME_W   = 64,
  parameter int MULT_W   = 32,
  parameter int PPM_W    = 32,
  parameter int TICK_NS  = 8,
  parameter int NUM_SH   = 9,
  parameter int DEN      = 15625,
  parameter int MAX_SPPM = 65536000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TICK_W-1:0] tick_count,
  input logic              trim_valid,
  input logic              trim_ready,
  input logic [PPM_W-1:0]  trim_sppm,
  input logic              step_valid,
  input logic [TIME_W-1:0] step_delta,
  input logic              set_valid,
  input logic [TIME_W-1:0] set_ns,
  input logic [TIME_W-1:0] time_ns,
  input logic [MULT_W-1:0] cur_mult
);
  localparam longint NOM      = longint'(TICK_NS) << FRAC_W;
  localparam longint MAX_TRIM = (longint'(MAX_SPPM) << NUM_SH) / DEN;
  localparam logic [MULT_W-1:0] LO_M = MULT_W'(NOM - MAX_TRIM);
  localparam logic [MULT_W-1:0] HI_M = MULT_W'(NOM + MAX_TRIM);

  logic unused_ok;
  assign unused_ok = ^trim_sppm;

  assert_mult_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mult >= LO_M && cur_mult <= HI_M);

  assert_mult_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_mult) |-> !$past(trim_ready));

  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trim_valid && trim_ready |=> !trim_ready);

  assert_set_loads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> time_ns == $past(set_ns));

  assert_step_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !set_valid && tick_count == $past(tick_count)
    |=> time_ns == $past(time_ns) + $past(step_delta));

  assert_hold_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid && !set_valid && tick_count == $past(tick_count)
    |=> $stable(time_ns));

  assert_no_backstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid && !set_valid |=> time_ns >= $past(time_ns));
endmodule

bind ttc_time_counter ttc_time_counter_chk #(
  .TICK_W(TICK_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W), .MULT_W(MULT_W),
  .PPM_W(PPM_W), .TICK_NS(TICK_NS), .NUM_SH(NUM_SH), .DEN(DEN),
  .MAX_SPPM(MAX_SPPM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_count(tick_count), .trim_valid(trim_valid),
  .trim_ready(trim_ready), .trim_sppm(trim_sppm), .step_valid(step_valid),
  .step_delta(step_delta), .set_valid(set_valid), .set_ns(set_ns),
  .time_ns(time_ns), .cur_mult(cur_mult)
);

// File: tb/sim_ttc_time_counter.sv
`timescale 1ns/1ps
module sim_ttc_time_counter;
  localparam logic [31:0] NOM = 32'd2147483648;

  typedef struct packed {
    logic signed [31:0] sppm;
    logic [31:0]        mult;
  } vec_t;

  // R5 / R6 trim vectors: request and expected multiplier
  localparam vec_t VECS [9] = '{
    '{32'sd0,            32'd2147483648},
    '{32'sd15625,        32'd2147484160},
    '{-32'sd15625,       32'd2147483136},
    '{32'sd100,          32'd2147483651},
    '{-32'sd7,           32'd2147483648},
    '{32'sd31250,        32'd2147484672},
    '{32'sd65536000,     32'd2149631131},
    '{32'sd100000000,    32'd2149631131},
    '{-32'sd2147483648,  32'd2145336165}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tick_count = 32'h1234;
  logic        trim_valid = 1'b0;
  logic        trim_ready;
  logic signed [31:0] trim_sppm = '0;
  logic        step_valid = 1'b0;
  logic [63:0] step_delta = '0;
  logic        set_valid = 1'b0;
  logic [63:0] set_ns = '0;
  logic [63:0] time_ns;
  logic [31:0] cur_mult;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ttc_time_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick_count(tick_count),
    .trim_valid(trim_valid), .trim_ready(trim_ready), .trim_sppm(trim_sppm),
    .step_valid(step_valid), .step_delta(step_delta),
    .set_valid(set_valid), .set_ns(set_ns),
    .time_ns(time_ns), .cur_mult(cur_mult)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_trim(input logic signed [31:0] s, output int lat);
    trim_valid = 1'b1;
    trim_sppm  = s;
    @(negedge clk);
    trim_valid = 1'b0;
    lat = 1;
    while (!trim_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R1 time in reset", time_ns, 64'd0);
    chk("R1 mult in reset", {32'd0, cur_mult}, {32'd0, NOM});
    chk("R1 ready in reset", {63'd0, trim_ready}, 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reference is reset tick", time_ns, 64'd0);

    tick_count = tick_count + 32'd5;
    @(negedge clk);
    chk("R2 five ticks", time_ns, 64'd40);
    for (int i = 0; i < 3; i++) begin
      tick_count = tick_count + 32'd1;
      @(negedge clk);
    end
    chk("R2 single ticks", time_ns, 64'd64);

    for (int v = 0; v < 9; v++) begin
      do_trim(VECS[v].sppm, lat);
      chk("R5 R6 trim vector", {32'd0, cur_mult}, {32'd0, VECS[v].mult});
      chk("R11 trim latency", {63'd0, lat <= 37}, 64'd1);
    end
    chk("R2 held ticks keep time", time_ns, 64'd64);
    do_trim(32'sd0, lat);

    tick_count = 32'hFFFF_FFFC;
    set_valid = 1'b1; set_ns = 64'd1000;
    @(negedge clk);
    set_valid = 1'b0;
    chk("R10 set discards ticks", time_ns, 64'd1000);
    tick_count = 32'd4;
    @(negedge clk);
    chk("R3 wrap", time_ns, 64'd1064);

    step_valid = 1'b1; step_delta = -64'sd100;
    @(negedge clk);
    step_valid = 1'b0;
    chk("R9 step back", time_ns, 64'd964);
    chk("R9 mult unchanged", {32'd0, cur_mult}, {32'd0, NOM});
    set_valid = 1'b1; set_ns = 64'd5000; step_valid = 1'b1; step_delta = 64'd7;
    @(negedge clk);
    set_valid = 1'b0; step_valid = 1'b0;
    chk("R10 set wins over step", time_ns, 64'd5000);

    do_trim(32'sd65536000, lat);
    set_valid = 1'b1; set_ns = 64'd0;
    @(negedge clk);
    set_valid = 1'b0;
    for (int i = 0; i < 125; i++) begin
      tick_count = tick_count + 32'd1;
      @(negedge clk);
    end
    chk("R4 no early carry", time_ns, 64'd1000);
    tick_count = tick_count + 32'd1;
    @(negedge clk);
    chk("R4 remainder carried", time_ns, 64'd1009);
    do_trim(32'sd0, lat);
    chk("R7 time kept across trim", time_ns, 64'd1009);
    tick_count = tick_count + 32'd10;
    @(negedge clk);
    chk("R7 new mult only on new ticks", time_ns, 64'd1089);

    trim_valid = 1'b1; trim_sppm = 32'sd15625;
    @(negedge clk);
    chk("R8 ready drops", {63'd0, trim_ready}, 64'd0);
    trim_sppm = -32'sd15625;
    repeat (3) @(negedge clk);
    trim_valid = 1'b0;
    lat = 0;
    while (!trim_ready && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    repeat (2) @(negedge clk);
    chk("R8 busy request ignored", {32'd0, cur_mult}, 64'd2147484160);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule